// File: doc/BRIEF.md
# Software-Strobed I2C Target Decoder

This block rebuilds I2C transactions from two line levels that software writes into output register bits. Each write is offered to the block as a snapshot: a data level, a clock level, and a valid strobe. The block compares every accepted snapshot with the one before it. From that comparison it finds start and stop conditions and falling clock edges, and it shifts each bit in MSB first. The first byte after a start is the address, and its bit 0 chooses between a read and a write. The block reports the address, each write byte and the end of the transfer to an attached register target as events.

During a read the block fetches bytes from the target. It returns one bit on each falling clock edge on a single data-return output, which software reads back as an input bit. The block acknowledges every byte on that output. Electrical open-drain behaviour, clock stretching and arbitration between controllers are outside the scope of this block.

Three valid/ready streams connect the block to the rest of the design. Snapshots come in on the update stream. Events go out on the event stream. Read bytes come in on the fetch stream. Back-pressure works as follows. An event stays on the event outputs, unchanged, until the target accepts it. A fetch request is raised only after the event before it has been accepted. The update stream stalls (ready low) while an event or a fetch is outstanding, and a snapshot offered while ready is low is not consumed.

Top module: `swi2c_decoder`

## Requirements
- R1: After reset, upd_ready is 1, evt_valid is 0, rd_ready is 0 and sda_ret is 1. The stored previous levels of data and clock are both 1, so a first snapshot with data 0 and clock 1 counts as a start.
- R2: In the idle state, an accepted snapshot in which data falls from 1 to 0 while clock is 1 is a start. After a start, a falling clock edge with data 0 begins the first byte. Bits are then shifted in MSB first, one on each falling clock edge. A rising clock edge does not shift a bit.
- R3: On the falling clock edge of the acknowledge slot that follows the first byte after a start, the block emits an address event with evt_kind = 0. That event carries evt_data equal to the byte with bit 0 cleared and evt_rw equal to bit 0 of the byte (1 = read).
- R4: In a write transfer, the falling clock edge of the acknowledge slot of each later byte emits a write event with evt_kind = 1 and evt_data equal to the byte.
- R5: Outside the idle state, an accepted snapshot in which data rises from 0 to 1 while clock is 1 is a stop, and the block returns to idle. If an address had been taken, the stop also emits an end event with evt_kind = 2. A stop that comes before any address is taken emits no event.
- R6: sda_ret is 0 in both acknowledge slots (after a byte that the controller sent, and after a byte that the block returned). It is 1 while the controller is shifting a byte in and while the block is idle.
- R7: After the address acknowledge of a read, the block raises rd_ready and loads rd_data when rd_valid is 1. It then shows the byte on sda_ret MSB first, moving one bit on each falling clock edge. The falling clock edge of the acknowledge slot after the eighth bit fetches the next byte in the same way.
- R8: While an event is pending, evt_kind, evt_data and evt_rw hold their values and upd_ready is 0. A snapshot offered while upd_ready is 0 has no effect on the decoded bits.
- R9: rd_ready stays 0 while an event is pending, so a fetch never overtakes the address event ahead of it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | A new line snapshot is offered |
| upd_ready | output | 1 | The block can take a snapshot |
| upd_sda | input | 1 | Data line level in the snapshot |
| upd_scl | input | 1 | Clock line level in the snapshot |
| sda_ret | output | 1 | Data level the target drives back |
| evt_valid | output | 1 | An event is pending |
| evt_ready | input | 1 | The target accepts the event |
| evt_kind | output | 2 | 0 address, 1 write byte, 2 end of transfer |
| evt_data | output | BYTE_W | Address (bit 0 cleared) or write byte; 0 for end |
| evt_rw | output | 1 | 1 when the open transfer is a read |
| rd_valid | input | 1 | The target offers a read byte |
| rd_ready | output | 1 | The block is fetching a read byte |
| rd_data | input | BYTE_W | Read byte from the target |

## Verification
The bench builds the block with its default byte width of eight bits. This makes whole address and data bytes reachable, so both the read/write selection in bit 0 and MSB-first order can be checked against bytes worked out by hand. The bench holds evt_ready low for several cycles to reach the stalled states: a pending address event that holds back a read fetch, and a snapshot offered while the update stream is stalled. A later write byte whose MSB is 0 would shift in an extra bit if the stalled snapshot had been taken, so the bench can see at the ports whether that snapshot was ignored.

// File: rtl/swi2c_pkg.sv
package swi2c_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ARM   = 3'd1,
    PH_TX    = 3'd2,
    PH_TXACK = 3'd3,
    PH_RX    = 3'd4,
    PH_RXACK = 3'd5
  } phase_t;

  typedef enum logic [1:0] {
    EV_ADDR  = 2'd0,
    EV_WDATA = 2'd1,
    EV_END   = 2'd2
  } ev_kind_t;
endpackage

// File: rtl/swi2c_line_track.sv
module swi2c_line_track #(
  parameter bit IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic sda,
  input  logic scl,
  output logic fall,
  output logic start_c,
  output logic stop_c
);
  logic prev_sda, prev_scl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_sda <= IDLE_LVL;
      prev_scl <= IDLE_LVL;
    end else if (take) begin
      prev_sda <= sda;
      prev_scl <= scl;
    end
  end

  // Conditions are judged from the stored snapshot against the offered one.
  assign fall    = prev_scl & ~scl;
  assign start_c = prev_sda & ~sda & scl;
  assign stop_c  = ~prev_sda & sda & scl;
endmodule

// File: rtl/swi2c_seq.sv
module swi2c_seq
  import swi2c_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              sda,
  input  logic              fall,
  input  logic              start_c,
  input  logic              stop_c,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  output phase_t            phase,
  output logic              addr_open,
  output logic              sda_ret,
  output logic              emit,
  output ev_kind_t          emit_kind,
  output logic [BYTE_W-1:0] emit_data,
  output logic              emit_rw,
  output logic              fetch_req
);
  localparam int IDX_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] shbuf;
  logic [IDX_W-1:0]  idx;
  logic              rd_mode;
  logic              stop_hit;
  logic              next_rd;
  logic              ack_fall;

  assign stop_hit = stop_c && (phase != PH_IDLE);
  assign next_rd  = addr_open ? rd_mode : shbuf[0];
  assign ack_fall = fall && (phase == PH_TXACK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      idx       <= '0;
      shbuf     <= '0;
      addr_open <= 1'b0;
      rd_mode   <= 1'b0;
    end else if (load) begin
      shbuf <= load_data;
    end else if (take) begin
      if (stop_hit) begin
        phase     <= PH_IDLE;
        addr_open <= 1'b0;
        rd_mode   <= 1'b0;
      end else begin
        case (phase)
          PH_IDLE: if (start_c) phase <= PH_ARM;
          PH_ARM: if (fall && !sda) begin
            phase <= PH_TX;
            idx   <= TOP_IDX;
          end
          PH_TX: if (fall) begin
            shbuf <= {shbuf[BYTE_W-2:0], sda};
            if (idx == '0) phase <= PH_TXACK;
            else           idx   <= idx - 1'b1;
          end
          PH_TXACK: if (fall) begin
            if (!addr_open) begin
              addr_open <= 1'b1;
              rd_mode   <= shbuf[0];
            end
            idx   <= TOP_IDX;
            phase <= next_rd ? PH_RX : PH_TX;
          end
          PH_RX: if (fall) begin
            shbuf <= {shbuf[BYTE_W-2:0], 1'b0};
            if (idx == '0) phase <= PH_RXACK;
            else           idx   <= idx - 1'b1;
          end
          PH_RXACK: if (fall) begin
            phase <= PH_RX;
            idx   <= TOP_IDX;
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (phase)
      PH_RX:             sda_ret = shbuf[BYTE_W-1];
      PH_TXACK, PH_RXACK: sda_ret = 1'b0;
      default:           sda_ret = 1'b1;
    endcase
  end

  assign emit = take && (ack_fall || (stop_hit && addr_open));

  always_comb begin
    if (stop_hit) begin
      emit_kind = EV_END;
      emit_data = '0;
      emit_rw   = rd_mode;
    end else if (addr_open) begin
      emit_kind = EV_WDATA;
      emit_data = shbuf;
      emit_rw   = rd_mode;
    end else begin
      emit_kind = EV_ADDR;
      emit_data = {shbuf[BYTE_W-1:1], 1'b0};
      emit_rw   = shbuf[0];
    end
  end

  assign fetch_req = take && fall && !stop_hit &&
                     (((phase == PH_TXACK) && next_rd) || (phase == PH_RXACK));
endmodule

// File: rtl/swi2c_xfer_port.sv
module swi2c_xfer_port
  import swi2c_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emit,
  input  ev_kind_t          emit_kind,
  input  logic [BYTE_W-1:0] emit_data,
  input  logic              emit_rw,
  input  logic              fetch_req,
  input  logic              evt_ready,
  input  logic              rd_valid,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              evt_valid,
  output ev_kind_t          evt_kind,
  output logic [BYTE_W-1:0] evt_data,
  output logic              evt_rw,
  output logic              rd_ready,
  output logic              load,
  output logic [BYTE_W-1:0] load_data,
  output logic              busy
);
  logic fetch_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_valid <= 1'b0;
      evt_kind  <= EV_ADDR;
      evt_data  <= '0;
      evt_rw    <= 1'b0;
    end else if (emit) begin
      evt_valid <= 1'b1;
      evt_kind  <= emit_kind;
      evt_data  <= emit_data;
      evt_rw    <= emit_rw;
    end else if (evt_ready) begin
      evt_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         fetch_pend <= 1'b0;
    else if (fetch_req) fetch_pend <= 1'b1;
    else if (load)      fetch_pend <= 1'b0;
  end

  assign rd_ready  = fetch_pend && !evt_valid;
  assign load      = rd_ready && rd_valid;
  assign load_data = rd_data;
  assign busy      = evt_valid || fetch_pend;
endmodule

// File: rtl/swi2c_decoder.sv
module swi2c_decoder
  import swi2c_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic              upd_sda,
  input  logic              upd_scl,
  output logic              sda_ret,
  output logic              evt_valid,
  input  logic              evt_ready,
  output logic [1:0]        evt_kind,
  output logic [BYTE_W-1:0] evt_data,
  output logic              evt_rw,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [BYTE_W-1:0] rd_data
);
  logic              take, fall, start_c, stop_c;
  logic              load, busy, emit, emit_rw, fetch_req, addr_open;
  logic [BYTE_W-1:0] load_data, emit_data;
  ev_kind_t          emit_kind, kind_q;
  phase_t            phase;

  assign upd_ready = !busy;
  assign take      = upd_valid && upd_ready;

  swi2c_line_track #(.IDLE_LVL(1'b1)) u_trk (
    .clk(clk), .rst_n(rst_n), .take(take), .sda(upd_sda), .scl(upd_scl),
    .fall(fall), .start_c(start_c), .stop_c(stop_c)
  );

  swi2c_seq #(.BYTE_W(BYTE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .take(take), .sda(upd_sda), .fall(fall),
    .start_c(start_c), .stop_c(stop_c), .load(load), .load_data(load_data),
    .phase(phase), .addr_open(addr_open), .sda_ret(sda_ret), .emit(emit),
    .emit_kind(emit_kind), .emit_data(emit_data), .emit_rw(emit_rw),
    .fetch_req(fetch_req)
  );

  swi2c_xfer_port #(.BYTE_W(BYTE_W)) u_port (
    .clk(clk), .rst_n(rst_n), .emit(emit), .emit_kind(emit_kind),
    .emit_data(emit_data), .emit_rw(emit_rw), .fetch_req(fetch_req),
    .evt_ready(evt_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .evt_valid(evt_valid), .evt_kind(kind_q), .evt_data(evt_data),
    .evt_rw(evt_rw), .rd_ready(rd_ready), .load(load),
    .load_data(load_data), .busy(busy)
  );

  assign evt_kind = kind_q;
endmodule

// File: rtl/swi2c_chk.sv
module swi2c_chk
  import swi2c_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd_ready,
  input logic              take,
  input logic              start_c,
  input logic              stop_c,
  input logic [2:0]        phase,
  input logic              addr_open,
  input logic              evt_valid,
  input logic              evt_ready,
  input logic [1:0]        evt_kind,
  input logic [BYTE_W-1:0] evt_data,
  input logic              evt_rw,
  input logic              rd_ready
);
  // R8: a pending event holds its payload until it is accepted
  p_evt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_ready |=> evt_valid && $stable(evt_data) &&
                                $stable(evt_kind) && $stable(evt_rw));

  // R8: snapshots stall while an event is pending
  p_upd_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> !upd_ready);

  // R7: a fetch in progress also stalls snapshots
  p_fetch_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> !upd_ready);

  // R9: no fetch while an event waits
  p_fetch_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> !rd_ready);

  // R5: an accepted stop returns to idle with no open address
  p_stop_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take && stop_c && (phase != PH_IDLE) |=> (phase == PH_IDLE) && !addr_open);

  // R2: an accepted start in idle arms the decoder
  p_start_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take && start_c && (phase == PH_IDLE) |=> (phase == PH_ARM));

  // R4: write events appear only inside an addressed transfer
  p_wdata_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && (evt_kind == 2'd1) |-> addr_open);
endmodule

bind swi2c_decoder swi2c_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_ready(upd_ready), .take(take),
  .start_c(start_c), .stop_c(stop_c), .phase(phase), .addr_open(addr_open),
  .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_kind(evt_kind),
  .evt_data(evt_data), .evt_rw(evt_rw), .rd_ready(rd_ready)
);

// File: tb/sim_swi2c_decoder.sv
module sim_swi2c_decoder;
  localparam int BW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_valid = 1'b0, upd_sda = 1'b1, upd_scl = 1'b1;
  logic upd_ready, sda_ret, evt_valid, evt_rw, rd_ready;
  logic evt_ready = 1'b1;
  logic rd_valid = 1'b1;
  logic [1:0] evt_kind;
  logic [BW-1:0] evt_data, rd_data;

  int checks = 0, errors = 0;
  logic [1:0]    ev_kind [0:31];
  logic [BW-1:0] ev_data [0:31];
  logic          ev_rw   [0:31];
  int ev_n = 0;
  int fetch_n = 0;
  logic [BW-1:0] rd_bytes [0:3];

  always #2 clk = ~clk;

  swi2c_decoder #(.BYTE_W(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_sda(upd_sda), .upd_scl(upd_scl), .sda_ret(sda_ret),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_kind(evt_kind),
    .evt_data(evt_data), .evt_rw(evt_rw), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data)
  );

  assign rd_data = rd_bytes[fetch_n & 3];

  always @(posedge clk) begin
    if (rst_n && evt_valid && evt_ready && ev_n < 32) begin
      ev_kind[ev_n] <= evt_kind;
      ev_data[ev_n] <= evt_data;
      ev_rw[ev_n]   <= evt_rw;
      ev_n          <= ev_n + 1;
    end
    if (rst_n && rd_valid && rd_ready) fetch_n <= fetch_n + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic snap(input logic d, input logic c);
    @(negedge clk);
    upd_valid = 1'b1; upd_sda = d; upd_scl = c;
    while (!upd_ready) @(negedge clk);
    @(posedge clk);
    #1 upd_valid = 1'b0;
  endtask

  task automatic start_seq();
    snap(1'b1, 1'b1); snap(1'b0, 1'b1); snap(1'b0, 1'b0);
  endtask

  task automatic stop_seq();
    snap(1'b0, 1'b0); snap(1'b0, 1'b1); snap(1'b1, 1'b1);
  endtask

  task automatic send_byte(input logic [BW-1:0] b);
    for (int i = BW - 1; i >= 0; i--) begin
      snap(b[i], 1'b0);
      snap(b[i], 1'b1);
      check("R6 idle-high while shifting in", sda_ret, 1'b1);
      snap(b[i], 1'b0);
    end
  endtask

  task automatic ack_slot();
    snap(1'b1, 1'b0);
    check("R6 ack low", sda_ret, 1'b0);
    snap(1'b1, 1'b1);
    snap(1'b1, 1'b0);
  endtask

  task automatic check_event(input int idx, input logic [1:0] k, input logic [BW-1:0] d,
                             input logic rw, input string req);
    check({req, " kind"}, ev_kind[idx], k);
    check({req, " data"}, ev_data[idx], d);
    check({req, " rw"}, ev_rw[idx], rw);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 upd_ready", upd_ready, 1'b1);
    check("R1 evt_valid", evt_valid, 1'b0);
    check("R1 rd_ready", rd_ready, 1'b0);
    check("R1 sda_ret", sda_ret, 1'b1);
  endtask

  // R1, R2, R3, R4, R5: first snapshot after reset is a start; write two bytes
  task automatic t_write();
    int base = ev_n;
    snap(1'b0, 1'b1);
    snap(1'b0, 1'b0);
    send_byte(8'h34); ack_slot();
    send_byte(8'hA5); ack_slot();
    send_byte(8'h3C); ack_slot();
    stop_seq();
    repeat (3) @(negedge clk);
    check("R5 write event count", ev_n - base, 4);
    check_event(base,     2'd0, 8'h34, 1'b0, "R3 address");
    check_event(base + 1, 2'd1, 8'hA5, 1'b0, "R4 first write");
    check_event(base + 2, 2'd1, 8'h3C, 1'b0, "R4 second write");
    check_event(base + 3, 2'd2, 8'h00, 1'b0, "R5 end");
    check("R5 idle after stop", sda_ret, 1'b1);
  endtask

  // R7, R9, R6: read two bytes, with the address event held back first
  task automatic t_read();
    int base = ev_n;
    int fbase = fetch_n;
    logic [BW-1:0] got;
    rd_bytes[0] = 8'hC3; rd_bytes[1] = 8'h5A; rd_bytes[2] = 8'hFF; rd_bytes[3] = 8'h00;
    fetch_n = 0;
    fbase = 0;
    evt_ready = 1'b0;
    start_seq();
    send_byte(8'h35);
    snap(1'b1, 1'b0); snap(1'b1, 1'b1); snap(1'b1, 1'b0);
    repeat (4) @(negedge clk);
    check("R9 fetch waits for event", rd_ready, 1'b0);
    check("R9 no fetch yet", fetch_n - fbase, 0);
    check("R8 stalled updates", upd_ready, 1'b0);
    evt_ready = 1'b1;
    for (int n = 0; n < 2; n++) begin
      got = '0;
      for (int i = BW - 1; i >= 0; i--) begin
        snap(1'b1, 1'b1);
        got[i] = sda_ret;
        snap(1'b1, 1'b0);
      end
      check("R7 read byte", got, rd_bytes[n]);
      check("R6 read ack low", sda_ret, 1'b0);
      snap(1'b1, 1'b1);
      snap(1'b1, 1'b0);
    end
    stop_seq();
    repeat (3) @(negedge clk);
    check("R7 fetch count", fetch_n - fbase, 3);
    check("R7 read event count", ev_n - base, 2);
    check_event(base,     2'd0, 8'h34, 1'b1, "R3 read address");
    check_event(base + 1, 2'd2, 8'h00, 1'b1, "R5 read end");
  endtask

  // R5: stop before an address, then stop in the middle of a byte
  task automatic t_stops();
    int base = ev_n;
    snap(1'b1, 1'b1); snap(1'b0, 1'b1); snap(1'b1, 1'b1);
    repeat (2) @(negedge clk);
    check("R5 no event without address", ev_n - base, 0);
    start_seq();
    send_byte(8'h50); ack_slot();
    snap(1'b1, 1'b0); snap(1'b1, 1'b1); snap(1'b1, 1'b0);
    stop_seq();
    repeat (3) @(negedge clk);
    check("R5 mid-byte stop count", ev_n - base, 2);
    check_event(base,     2'd0, 8'h50, 1'b0, "R5 address before cut");
    check_event(base + 1, 2'd2, 8'h00, 1'b0, "R5 end after cut");
  endtask

  // R8: held event and a snapshot offered while stalled
  task automatic t_backpressure();
    int base = ev_n;
    evt_ready = 1'b0;
    start_seq();
    send_byte(8'h50); ack_slot();
    repeat (3) @(negedge clk);
    check("R8 event held", evt_valid, 1'b1);
    check("R8 payload held", evt_data, 8'h50);
    check("R8 stall", upd_ready, 1'b0);
    upd_valid = 1'b1; upd_sda = 1'b0; upd_scl = 1'b1;
    repeat (3) @(negedge clk);
    upd_valid = 1'b0; upd_sda = 1'b1; upd_scl = 1'b0;
    evt_ready = 1'b1;
    repeat (2) @(negedge clk);
    send_byte(8'h11); ack_slot();
    stop_seq();
    repeat (3) @(negedge clk);
    check("R8 event count", ev_n - base, 3);
    check_event(base,     2'd0, 8'h50, 1'b0, "R8 held address");
    check_event(base + 1, 2'd1, 8'h11, 1'b0, "R8 stalled snapshot ignored");
    check_event(base + 2, 2'd2, 8'h00, 1'b0, "R8 end");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_write();
    t_read();
    t_stops();
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule